// File: doc/BRIEF.md
# Adaptive Contention Backoff Unit

This unit sits beside one core's cache controller. It watches the remote synchronization read requests that reach the core, treats each one as a sign of contention on a synchronization variable, and uses them to build up a waiting time. The next local synchronization read that misses in the cache is held for that many cycles before it is allowed to go out to the shared cache. Reads that hit are let through at once.

Two counters set the wait. The backoff count grows by the current step size on every contention hint. The step size itself starts at a configured default and grows by that same default after each group of N hints, so a burst of contention makes the wait grow faster and faster. Once a held miss is let out, or when the core signals a successful acquire through the clear input, both counters go back to their starting values. Both counters stop at their largest value rather than wrapping.

The cache controller presents a read request with a hit flag and holds it until the grant. The grant is combinational from the request and the present backoff count. A waiting miss counts the backoff down by one per cycle, and hints that arrive meanwhile add to what is left.

Top module: `contention_backoff`

## Requirements
- R1: After reset the backoff count is 0, the step size equals the configured default and the hint group counter is 0, so a miss is granted in the same cycle it is requested and the first hint adds exactly the default.
- R2: Each cycle with the hint input high, and no restart in that cycle, adds the current step size to the backoff count.
- R3: The hint that completes a group of N hints since the last restart (N is the step threshold input; 0 behaves as 1) adds the default to the step size after its own addition to the backoff count, and the group counter starts again from 0.
- R4: A miss request (request high, hit flag low) presented while the backoff count is B is granted after exactly B rising clock edges; the count falls by one on each of them.
- R5: A hit request (request high, hit flag high) is granted in the same cycle whatever the backoff count, and neither lowers nor raises that count.
- R6: The clock edge that ends a granted miss sets the backoff count to 0, the step size to the default and the group counter to 0; a hint in that same cycle is discarded.
- R7: The clear input has the same effect as R6 on its clock edge, with any hint in that cycle discarded.
- R8: The backoff count stops at its maximum (255 by default) and the step size stops at its maximum (63 by default) instead of wrapping.
- R9: A hint that arrives while a miss is counting down adds the step size to the remaining wait, so the total wait becomes the starting count plus that step size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Successful acquire; restarts both counters |
| hint_i | input | 1 | One-cycle pulse per remote synchronization read request |
| rd_req_i | input | 1 | Local synchronization read request, held until granted |
| rd_hit_i | input | 1 | Request hits in the local cache |
| cfg_incr_i | input | IW (6) | Default step size |
| cfg_step_i | input | NW (4) | Hints per step-size increase (N) |
| rd_gnt_o | output | 1 | Request may proceed |

## Verification
The grant is combinational, so a hit is due in the cycle it is requested and a miss after as many rising edges as the backoff count held when it was raised; the bench raises the request just after a falling edge and counts falling edges until the grant is seen, a short settle delay after each. Hints, clear and configuration are driven at falling edges and take effect on the next rising edge, so their result is first due at the following falling edge. Sweeps over default step, threshold and hint count compare each measured wait against an arithmetic model of the two counters, including saturation, hints during a wait and hints on the restart edge.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

    // Kind of local synchronization read seen this cycle
    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_HIT  = 2'd1,
        REQ_MISS = 2'd2
    } req_kind_e;

    // Per-cycle control shared by the counters
    typedef struct packed {
        logic restart;    // return counters to their start values
        logic hint;       // a contention hint that counts
        logic countdown;  // a miss is waiting this cycle
    } ctl_t;

    function automatic req_kind_e classify(logic req, logic hit);
        if (!req)     return REQ_IDLE;
        else if (hit) return REQ_HIT;
        else          return REQ_MISS;
    endfunction

    // Unsigned clamp to an upper limit
    function automatic logic [31:0] clamp_u(logic [31:0] v, logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/hint_divider.sv
module hint_divider #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic          hint_i,
    input  logic [NW-1:0] cfg_step_i,
    output logic          step_o
);
    logic [NW-1:0] cnt_q;
    logic [NW:0]   cnt_inc;
    logic          wrap;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{NW{1'b0}}, 1'b1};
        wrap    = (cnt_inc >= {1'b0, cfg_step_i});
        step_o  = hint_i && !restart_i && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (hint_i) begin
            cnt_q <= wrap ? '0 : cnt_inc[NW-1:0];
        end
    end

    // R3
    div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (cnt_q == '0));

endmodule

// File: rtl/incr_ctrl.sv
module incr_ctrl #(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic          step_i,
    input  logic [IW-1:0] cfg_incr_i,
    output logic [IW-1:0] incr_o
);
    logic [IW-1:0] i_q;
    logic [IW:0]   i_sum;
    logic [IW-1:0] i_grown;

    always_comb begin
        i_sum   = {1'b0, i_q} + {1'b0, cfg_incr_i};
        i_grown = i_sum[IW] ? {IW{1'b1}} : i_sum[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            i_q <= cfg_incr_i;
        end else if (step_i) begin
            i_q <= i_grown;
        end
    end

    assign incr_o = i_q;

    // R3
    i_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !restart_i |=> (i_q >= $past(i_q)));

    // R6
    i_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (i_q == $past(cfg_incr_i)));

endmodule

// File: rtl/backoff_ctr.sv
module backoff_ctr
    import cbk_pkg::*;
#(
    parameter int BW = 8,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl_i,
    input  logic [IW-1:0] incr_i,
    output logic [BW-1:0] b_o,
    output logic          zero_o
);
    localparam logic [31:0] BMAX = 32'((64'd1 << BW) - 64'd1);

    logic [BW-1:0] b_q;
    logic [BW:0]   b_sum;
    logic [BW-1:0] b_next;

    always_comb begin
        b_sum = {1'b0, b_q};
        if (ctl_i.hint)      b_sum = b_sum + (BW+1)'(incr_i);
        if (ctl_i.countdown) b_sum = b_sum - {{BW{1'b0}}, 1'b1};
        b_next = BW'(clamp_u(32'(b_sum), BMAX));
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.restart) begin
            b_q <= '0;
        end else begin
            b_q <= b_next;
        end
    end

    assign b_o    = b_q;
    assign zero_o = (b_q == '0);

    // R2
    b_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.hint && !ctl_i.restart && !ctl_i.countdown) |=> (b_q >= $past(b_q)));

    // R4
    b_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.countdown && !ctl_i.hint && !ctl_i.restart) |=> (b_q == $past(b_q) - 1'b1));

    // R6
    b_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_i.restart |=> (b_q == '0));

endmodule

// File: rtl/contention_backoff.sv
module contention_backoff
    import cbk_pkg::*;
#(
    parameter int BW = 8,
    parameter int IW = 6,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          hint_i,
    input  logic          rd_req_i,
    input  logic          rd_hit_i,
    input  logic [IW-1:0] cfg_incr_i,
    input  logic [NW-1:0] cfg_step_i,
    output logic          rd_gnt_o
);
    req_kind_e     kind;
    ctl_t          ctl;
    logic          step;
    logic [IW-1:0] incr;
    logic [BW-1:0] bcount;
    logic          bzero;
    logic          miss_go;

    always_comb begin
        kind          = classify(rd_req_i, rd_hit_i);
        miss_go       = (kind == REQ_MISS) && bzero;
        rd_gnt_o      = (kind == REQ_HIT) || miss_go;
        ctl.restart   = clear_i || miss_go;
        ctl.hint      = hint_i && !ctl.restart;
        ctl.countdown = (kind == REQ_MISS) && !bzero;
    end

    hint_divider #(.NW(NW)) u_div (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (ctl.restart),
        .hint_i     (ctl.hint),
        .cfg_step_i (cfg_step_i),
        .step_o     (step)
    );

    incr_ctrl #(.IW(IW)) u_incr (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (ctl.restart),
        .step_i     (step),
        .cfg_incr_i (cfg_incr_i),
        .incr_o     (incr)
    );

    backoff_ctr #(.BW(BW), .IW(IW)) u_boff (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .incr_i (incr),
        .b_o    (bcount),
        .zero_o (bzero)
    );

    // R5
    hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind == REQ_HIT) && !hint_i && !clear_i) |=> $stable(bcount));

    // R9
    wait_extend_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind == REQ_MISS) && !bzero && hint_i && !clear_i) |=> (bcount >= $past(bcount)));

endmodule

// File: tb/tb_contention_backoff.sv
module tb_contention_backoff;
    localparam int IW = 6;
    localparam int NW = 4;
    localparam int BMAX = 255;
    localparam int IMAX = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear_i = 1'b0, hint_i = 1'b0, rd_req_i = 1'b0, rd_hit_i = 1'b0;
    logic [IW-1:0] cfg_incr_i = 6'd1;
    logic [NW-1:0] cfg_step_i = 4'd1;
    logic rd_gnt_o;

    int checks = 0, fails = 0;
    int mB = 0, mI = 1, mC = 0, mD = 1, mN = 1;

    always #10 clk = ~clk;

    contention_backoff dut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .hint_i(hint_i),
        .rd_req_i(rd_req_i), .rd_hit_i(rd_hit_i),
        .cfg_incr_i(cfg_incr_i), .cfg_step_i(cfg_step_i), .rd_gnt_o(rd_gnt_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic m_restart();
        mB = 0; mI = mD; mC = 0;
    endtask

    task automatic m_hint();
        int add;
        add = mI;
        if (mC + 1 >= mN) begin
            mC = 0;
            mI = imin(mI + mD, IMAX);
        end else begin
            mC++;
        end
        mB = imin(mB + add, BMAX);
    endtask

    task automatic set_cfg(input int d, input int n);
        @(negedge clk);
        cfg_incr_i = IW'(d); cfg_step_i = NW'(n); clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        mD = d; mN = n; m_restart();
    endtask

    task automatic hints(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); hint_i = 1'b1;
            @(negedge clk); hint_i = 1'b0;
            m_hint();
        end
    endtask

    // Raise a miss; hint once when the wait count equals ext_at (-1: never)
    task automatic miss_wait(input int ext_at, output int w);
        @(negedge clk);
        rd_req_i = 1'b1; rd_hit_i = 1'b0;
        #1;
        w = 0;
        while (!rd_gnt_o && w < 2000) begin
            @(negedge clk);
            w++;
            hint_i = (w == ext_at);
            #1;
        end
        hint_i = 1'b0;
        @(negedge clk);
        rd_req_i = 1'b0;
        m_restart();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: no request, no grant; miss granted at once after reset
        chk(rd_gnt_o == 1'b0, "R1 idle grant", int'(rd_gnt_o), 0);
        miss_wait(-1, w);
        chk(w == 0, "R1 wait after reset", w, 0);
        hints(1);
        exp = mB;
        miss_wait(-1, w);
        chk(w == exp, "R1 first hint adds default", w, exp);

        // R2 R3 R4: sweep of default, threshold and hint count
        for (int d = 1; d <= 3; d++) begin
            for (int n = 0; n <= 4; n++) begin
                for (int k = 0; k <= 7; k++) begin
                    set_cfg(d, n);
                    hints(k);
                    exp = mB;
                    miss_wait(-1, w);
                    chk(w == exp, $sformatf("R2/R3/R4 d=%0d n=%0d k=%0d", d, n, k), w, exp);
                end
            end
        end

        // R5: hit granted at once and leaves the count alone
        set_cfg(2, 2);
        hints(3);
        @(negedge clk);
        rd_req_i = 1'b1; rd_hit_i = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(rd_gnt_o == 1'b1, "R5 hit grant", int'(rd_gnt_o), 1);
            @(negedge clk);
        end
        rd_req_i = 1'b0; rd_hit_i = 1'b0;
        exp = mB;
        miss_wait(-1, w);
        chk(w == exp, "R5 count kept over hit", w, exp);

        // R6: restart after a granted miss and drop of coincident hint
        set_cfg(4, 1);
        hints(2);
        exp = mB;
        miss_wait(-1, w);
        chk(w == exp, "R6 wait before restart", w, exp);
        hints(1);
        miss_wait(-1, w);
        chk(w == 4, "R6 step back to default", w, 4);
        @(negedge clk);
        rd_req_i = 1'b1; hint_i = 1'b1;
        #1;
        chk(rd_gnt_o == 1'b1, "R6 grant with zero count", int'(rd_gnt_o), 1);
        @(negedge clk);
        rd_req_i = 1'b0; hint_i = 1'b0;
        miss_wait(-1, w);
        chk(w == 0, "R6 hint on grant edge dropped", w, 0);
        hints(1);
        miss_wait(-1, w);
        chk(w == 4, "R6 step unchanged by dropped hint", w, 4);

        // R7: clear restarts counters
        set_cfg(3, 1);
        hints(3);
        @(negedge clk); clear_i = 1'b1; hint_i = 1'b1;
        @(negedge clk); clear_i = 1'b0; hint_i = 1'b0;
        m_restart();
        miss_wait(-1, w);
        chk(w == 0, "R7 clear zeroes count", w, 0);
        hints(1);
        miss_wait(-1, w);
        chk(w == 3, "R7 clear restores step", w, 3);

        // R8: step size saturates at 63, count at 255
        set_cfg(30, 1);
        hints(3);
        miss_wait(-1, w);
        chk(w == 153, "R8 step saturation", w, 153);
        set_cfg(20, 1);
        hints(12);
        miss_wait(-1, w);
        chk(w == BMAX, "R8 count saturation", w, BMAX);

        // R9: hint during countdown extends wait
        for (int b = 3; b <= 6; b++) begin
            set_cfg(b, 2);
            hints(1);
            exp = mB + mI;
            miss_wait(2, w);
            chk(w == exp, $sformatf("R9 extend b=%0d", b), w, exp);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule